// File: doc/BRIEF.md
# Write-Strobe Usage Monitor for a Peripheral Bus Link

This block sits passively beside an APB link and watches how the requester drives the byte-lane write strobe. It samples the select, enable, direction, strobe and ready signals every clock. It never drives the bus and ignores data and address. Whenever the requester breaks a strobe rule, the monitor raises a one-cycle error pulse and a sticky error flag, and it reports a two-bit code that names the rule.

Two rules are enforced. First, a read must carry an all-zero strobe. Second, the strobe must not move between any two consecutive cycles of one transfer, from the setup cycle through the access cycle that completes with ready high. On writes every strobe pattern is legal, including all-zero and gapped patterns such as 0101 and 1010. A zero-strobe write is still a real transfer: it completes with ready like any other write. Each transfer is judged on its own, so back-to-back transfers may carry different strobes.

A small tracker state machine follows the transfer phase. It has three states. `PH_IDLE` means the previous cycle was not part of an open transfer. `PH_SETUP` means the previous cycle was a setup cycle (select high, enable low). `PH_ACCESS` means the previous cycle was an access cycle still waiting for ready. The next state is chosen as follows:
- select low leads to `PH_IDLE`;
- select high with enable low leads to `PH_SETUP`;
- select and enable high with ready low leads to `PH_ACCESS`;
- select, enable and ready all high (completion) leads to `PH_IDLE`.

A cycle with select high while the tracker is in `PH_IDLE` is the opening cycle of a new transfer.

Top module: `strobe_watch`

## Requirements
- R1: While reset is asserted and after it is released with no violation, `err_pulse` = 0, `err_flag` = 0 and `err_code` = 2'b00.
- R2: In the opening cycle of a transfer with `sel` = 1 and `write` = 0 and a non-zero `strb`, the next cycle shows `err_pulse` = 1 and `err_code` = 2'b01.
- R3: A write whose strobe is held constant is never flagged, for all 16 strobe values including 4'b0000, 4'b0101 and 4'b1010.
- R4: Inside one transfer (`sel` high, not the opening cycle), any change of `strb` from the previous cycle gives `err_pulse` = 1 and `err_code` = 2'b10 in the next cycle, once per change.
- R5: Cycles with `sel` = 0 are never flagged, whatever `strb`, `write` and `enable` carry.
- R6: A cycle with `sel`, `enable` and `ready` all 1 completes the transfer. A zero-strobe write completes this way. The next `sel`-high cycle opens a new transfer, so a different strobe there is not an instability.
- R7: `err_flag` is set by any violation and holds until `clr` (synchronous) or reset. A violation detected in the same cycle as `clr` wins, and the flag stays set.
- R8: `err_pulse` is high for exactly one cycle per violation. `err_code` holds the code of the most recent violation. `clr` without a violation returns `err_code` to 2'b00.
- R9: On a read whose strobe is zero in the opening cycle but changes in a later cycle, the violation is reported with code 2'b10, not 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| clr | input | 1 | Synchronous clear of the sticky flag and code |
| sel | input | 1 | Observed peripheral select |
| enable | input | 1 | Observed enable (access phase) |
| write | input | 1 | Observed direction, 1 = write |
| strb | input | LANES (4) | Observed byte-lane write strobe |
| ready | input | 1 | Observed completer ready |
| err_flag | output | 1 | Sticky violation flag |
| err_pulse | output | 1 | One-cycle pulse per detected violation |
| err_code | output | 2 | Last violation: 01 read strobe non-zero, 10 strobe unstable |

## Verification
The assertions assume that all observed inputs are known (not X) whenever reset is released. They also assume that `strb` is already defined in the cycle just before the first post-reset cycle, because the stability property compares against it. The bench meets these assumptions by holding every input at zero during reset and by changing inputs only at the falling edge. The random stimulus builds legal setup/access sequences with random wait states, mixed in with deliberately faulty read strobes, single-lane strobe flips and idle cycles carrying junk values. Because the monitor must accept any input sequence, the stimulus also includes transfers abandoned when select drops.

// File: rtl/strobe_watch_pkg.sv
`timescale 1ns/1ps
package strobe_watch_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'b00,
        ERR_READ_STRB = 2'b01,
        ERR_UNSTABLE  = 2'b10
    } err_code_t;
endpackage

// File: rtl/xfer_tracker.sv
`timescale 1ns/1ps
module xfer_tracker
    import strobe_watch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic enable,
    input  logic ready,
    output logic opening
);
    phase_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = PH_IDLE;
        opening = 1'b0;
        unique case (state_q)
            PH_IDLE:   opening = sel;
            PH_SETUP:  opening = 1'b0;
            PH_ACCESS: opening = 1'b0;
            default:   opening = sel;
        endcase
        if (sel && !enable)              state_d = PH_SETUP;
        else if (sel && enable && !ready) state_d = PH_ACCESS;
        else                              state_d = PH_IDLE;
    end
endmodule

// File: rtl/strobe_rules.sv
`timescale 1ns/1ps
module strobe_rules
    import strobe_watch_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             write,
    input  logic             opening,
    input  logic [LANES-1:0] strb,
    output err_code_t        viol
);
    logic [LANES-1:0] prev_q;
    logic [LANES-1:0] lane_moved;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= strb;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_moved[i] = strb[i] ^ prev_q[i];
    end

    always_comb begin
        viol = ERR_NONE;
        if (sel) begin
            if (opening) begin
                if (!write && (|strb)) viol = ERR_READ_STRB;
            end else if (|lane_moved) begin
                viol = ERR_UNSTABLE;
            end
        end
    end
endmodule

// File: rtl/err_report.sv
`timescale 1ns/1ps
module err_report
    import strobe_watch_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  err_code_t viol,
    output logic      err_flag,
    output logic      err_pulse,
    output logic [1:0] err_code
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag  <= 1'b0;
            err_pulse <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            err_pulse <= (viol != ERR_NONE);
            if (viol != ERR_NONE) begin
                err_flag <= 1'b1;
                err_code <= viol;
            end else if (clr) begin
                err_flag <= 1'b0;
                err_code <= ERR_NONE;
            end
        end
    end

    // R7: every pulse is accompanied by the sticky flag
    p_pulse_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> err_flag);

    // R7: the flag only drops through clr
    p_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr) |=> err_flag);

    // R8: a pulse always carries a real rule code
    p_pulse_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (err_code == 2'b01 || err_code == 2'b10));

    // R7: clear with no new violation empties flag and code
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && viol == ERR_NONE) |=> (!err_flag && err_code == 2'b00));
endmodule

// File: rtl/strobe_watch.sv
`timescale 1ns/1ps
module strobe_watch
    import strobe_watch_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sel,
    input  logic             enable,
    input  logic             write,
    input  logic [LANES-1:0] strb,
    input  logic             ready,
    output logic             err_flag,
    output logic             err_pulse,
    output logic [1:0]       err_code
);
    logic      opening;
    err_code_t viol;

    xfer_tracker u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .enable  (enable),
        .ready   (ready),
        .opening (opening)
    );

    strobe_rules #(.LANES(LANES)) u_rules (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .write   (write),
        .opening (opening),
        .strb    (strb),
        .viol    (viol)
    );

    err_report u_rep (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .viol      (viol),
        .err_flag  (err_flag),
        .err_pulse (err_pulse),
        .err_code  (err_code)
    );

    // R5: idle cycles never produce a pulse
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !err_pulse);

    // R3: the opening cycle of a write is never flagged
    p_write_open_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && write && opening) |=> !err_pulse);

    // R2: read opening with a non-zero strobe is reported as code 01
    p_read_strb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !write && opening && (|strb)) |=> (err_pulse && err_code == 2'b01));

    // R4: an unchanged strobe inside a transfer gives no pulse
    p_held_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !opening && $stable(strb)) |=> !err_pulse);
endmodule

// File: tb/sim_strobe_watch.sv
`timescale 1ns/1ps
module sim_strobe_watch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0, sel = 1'b0, en = 1'b0, wr = 1'b0, rdy = 1'b0;
    logic [3:0] strb = 4'b0000;
    logic       err_flag, err_pulse;
    logic [1:0] err_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expectation state, derived from the requirements
    bit         m_open_pending;   // 1 when a transfer is in progress
    logic [3:0] m_last;
    logic       m_flag;
    logic [1:0] m_code;

    always #2.5 clk = ~clk;

    strobe_watch u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .sel(sel), .enable(en),
        .write(wr), .strb(strb), .ready(rdy),
        .err_flag(err_flag), .err_pulse(err_pulse), .err_code(err_code)
    );

    function automatic logic [1:0] rule_code(input bit in_xfer, input logic s,
                                             input logic w, input logic [3:0] st,
                                             input logic [3:0] last);
        if (!s) return 2'b00;
        if (!in_xfer) return (!w && st != 4'b0000) ? 2'b01 : 2'b00;
        return (st != last) ? 2'b10 : 2'b00;
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {pulse,flag,code} got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic s, input logic e, input logic w, input logic r,
                        input logic c, input logic [3:0] st, input string tag);
        logic [1:0] v;
        string t;
        @(negedge clk);
        sel = s; en = e; wr = w; rdy = r; clr = c; strb = st;
        v = rule_code(m_open_pending, s, w, st, m_last);
        if (v != 2'b00) begin m_flag = 1'b1; m_code = v; end
        else if (c) begin m_flag = 1'b0; m_code = 2'b00; end
        m_open_pending = s && !(e && r);
        m_last = st;
        @(posedge clk); #1;
        t = tag;
        if (t == "") t = !s ? "R5" : (v == 2'b01 ? "R2" : (v == 2'b10 ? "R4" : "R3"));
        check(t, {err_pulse, err_flag, err_code}, {(v != 2'b00), m_flag, m_code});
    endtask

    task automatic xfer(input logic w, input logic [3:0] s0, input logic [3:0] s1,
                        input int waits, input string tag);
        step(1'b1, 1'b0, w, 1'b0, 1'b0, s0, tag);
        for (int k = 0; k < waits; k++) step(1'b1, 1'b1, w, 1'b0, 1'b0, s1, tag);
        step(1'b1, 1'b1, w, 1'b1, 1'b0, s1, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_open_pending = 1'b0; m_last = 4'b0000; m_flag = 1'b0; m_code = 2'b00;
        repeat (3) @(posedge clk);
        #1 check("R1", {err_pulse, err_flag, err_code}, 4'b0000);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", {err_pulse, err_flag, err_code}, 4'b0000);

        // R3: every write strobe value, held, with a wait state
        for (int v = 0; v < 16; v++) xfer(1'b1, 4'(v), 4'(v), 1, "R3");
        xfer(1'b1, 4'b0101, 4'b0101, 0, "R3");
        xfer(1'b1, 4'b1010, 4'b1010, 2, "R3");

        // R6: zero-strobe write completes, then new transfers back to back
        xfer(1'b1, 4'b0000, 4'b0000, 0, "R6");
        xfer(1'b1, 4'b1111, 4'b1111, 0, "R6");
        xfer(1'b0, 4'b0000, 4'b0000, 1, "R6");
        xfer(1'b1, 4'b0110, 4'b0110, 0, "R6");

        // R5: idle junk
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1111, "R5");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b1001, "R5");

        // R2 then R8: read with gapped strobe, pulse for one cycle only
        xfer(1'b0, 4'b0101, 4'b0101, 1, "R2");
        idle(2, "R8");

        // R7: flag held through idle, cleared by clr
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, "R7");
        // R9: read zero at open, changes later
        xfer(1'b0, 4'b0000, 4'b0010, 1, "R9");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, "R8");
        // R4: write strobe flips during the access phase
        xfer(1'b1, 4'b0011, 4'b0111, 2, "R4");
        // R7: violation in the same cycle as clr wins
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0110, "R7");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0110, "R7");
        idle(1, "R7");

        // random mixture
        for (int n = 0; n < 1500; n++) begin
            int kind;
            logic w;
            logic [3:0] s0, s1;
            kind = int'($urandom % 10);
            w = (kind < 6);
            s0 = w ? 4'($urandom % 16) : 4'b0000;
            if (kind == 8) s0 = 4'(1 + $urandom % 15);
            s1 = s0;
            if (kind == 9) s1 = s0 ^ (4'b0001 << ($urandom % 4));
            if (kind == 7 && ($urandom % 2) == 1) begin
                step(1'b1, 1'b0, w, 1'b0, 1'b0, s0, "");
                step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'($urandom % 16), "");
            end else begin
                xfer(w, s0, s1, int'($urandom % 3), "");
            end
            for (int k = 0; k < int'($urandom % 3); k++)
                step(1'b0, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                     1'(($urandom % 8) == 0), 4'($urandom % 16), "");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule